// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that software drives through three 32-bit registers on a simple write-strobe bus: a control word, a data word and a clock-divider word. Software places a byte in the data register, programs the serial clock period through a bit field of the divider word, then writes the control word with the launch bit set. The block shifts the byte out on the serial output, most significant bit first, and samples the serial input at the same time. When the eighth bit is done the received byte replaces the data register contents and the launch bit, which reads back as the busy flag, drops to zero.

Only clock mode 0 is produced: the serial clock rests low, the input is captured on each rising edge and the output moves on each falling edge. The chip-select output follows its own sticky control bit, independent of the launch bit, so software can keep a device selected over several consecutive bytes and release it with a later control write. The transaction-code, byte-count, byte-order and interface-mode fields are held and read back but do not alter the one-byte data exchange that the block performs.

Reads are combinational from the register address; writes take effect at the clock edge on which the write strobe is high. While a byte is in flight every register write is discarded.

Top module: `byte_spi_master`

## Requirements
- R1: After reset the control, data and divider registers read 0, chip select is inactive (`cs_n_o` = 1), and `sclk_o` and `mosi_o` are 0.
- R2: The control register (address 0) stores and reads back bit 30 (interface mode), bit 22 (byte order), bit 21 (select enable), bits 17:16 (byte count minus one) and bits 10:8 (transaction code); every other bit except bit 31 reads 0.
- R3: `cs_n_o` is 0 exactly while control bit 21 is 1, and it does not change during a transfer.
- R4: A control write with bit 31 set while idle launches a transfer; control bit 31 then reads 1 for exactly 8 × E clock cycles after the accepting edge, and 0 from then on, where E is the effective divider of R8.
- R5: The byte in the data register is sent on `mosi_o` most significant bit first, one bit per serial clock period, with `mosi_o` stable while `sclk_o` is high.
- R6: `miso_i` is sampled on each rising edge of `sclk_o`, first bit as the most significant; once bit 31 reads 0 the data register (address 1) holds the received byte in bits 7:0 with bits 31:8 reading 0.
- R7: `sclk_o` is low whenever no transfer is running; in each of the 8 periods it is low for floor(E/2) clock cycles and then high for E − floor(E/2) clock cycles.
- R8: The serial clock period E in clock cycles equals the divider register bits 20:4, except that a field value of 0 or 1 gives E = 2.
- R9: The divider register (address 2) reads back the whole word last written; bits outside 20:4 have no effect on timing.
- R10: Any register write while a transfer is running is ignored: no new transfer starts and the control, divider and data contents are unchanged, apart from the received byte loaded at completion.
- R11: A data write stores bits 7:0 as the next byte to send; a transfer launched without a new data write sends the byte received by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 data, 2 divider, 3 unused (reads 0) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
Busy stays visible for exactly 8 × E cycles counted from the edge that accepts the launching write, so the bench polls the control register once per cycle between edges and compares the count of busy samples with that product. The received byte lands in the data register on the very edge at which busy drops, so the bench reads it only after the first idle sample. Phase lengths are counted by sampling `sclk_o` and `cs_n_o` at every falling clock edge, and the sent byte is taken from `mosi_o` at every rising serial clock edge, where it has been stable for at least one cycle.

// File: rtl/byte_spi_pkg.sv
package byte_spi_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DIV_LSB = 4;
  localparam int unsigned DIV_MSB = 20;
  localparam int unsigned DIV_W   = DIV_MSB - DIV_LSB + 1;

  // control word bit positions (software visible)
  localparam int unsigned CTL_GO    = 31;
  localparam int unsigned CTL_IFM   = 30;
  localparam int unsigned CTL_ORD   = 22;
  localparam int unsigned CTL_SEL   = 21;
  localparam int unsigned CTL_CNT_L = 16;
  localparam int unsigned CTL_OP_L  = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_DATA = 2'd1,
    RA_DIV  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       if_mode;
    logic       big_end;
    logic       sel_en;
    logic [1:0] cnt_m1;
    logic [2:0] op_code;
  } ctrl_t;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_LOW  = 2'd1,
    EN_HIGH = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_phase_calc.sv
module spi_phase_calc #(
  parameter int unsigned DIV_W = 17
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] lo_o,
  output logic [DIV_W-1:0] hi_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] eff;

  always_comb begin
    eff  = (div_i < MIN_DIV) ? MIN_DIV : div_i;
    lo_o = eff >> 1;
    hi_o = eff - lo_o;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import byte_spi_pkg::*;
#(
  parameter int unsigned BW    = 8,
  parameter int unsigned DIV_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BW-1:0]    tx_i,
  input  logic [DIV_W-1:0] lo_i,
  input  logic [DIV_W-1:0] hi_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BW-1:0]    rx_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int unsigned BIT_W = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BW - 1);

  eng_state_e       state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [BW-1:0]    tx_q;
  logic [BW-1:0]    rx_q;
  logic             sclk_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EN_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        EN_IDLE: begin
          if (start_i) begin
            state_q <= EN_LOW;
            cnt_q   <= lo_i - 1'b1;
            bit_q   <= '0;
            tx_q    <= tx_i;
          end
        end
        EN_LOW: begin
          if (cnt_zero) begin
            state_q <= EN_HIGH;
            sclk_q  <= 1'b1;
            cnt_q   <= hi_i - 1'b1;
            rx_q    <= {rx_q[BW-2:0], miso_i};
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        EN_HIGH: begin
          if (cnt_zero) begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              state_q <= EN_IDLE;
            end else begin
              state_q <= EN_LOW;
              cnt_q   <= lo_i - 1'b1;
              bit_q   <= bit_q + 1'b1;
              tx_q    <= {tx_q[BW-2:0], 1'b0};
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= EN_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != EN_IDLE);
  assign done_o = (state_q == EN_HIGH) && cnt_zero && (bit_q == LAST_BIT);
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[BW-1];
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import byte_spi_pkg::*;
#(
  parameter int unsigned RW    = 32,
  parameter int unsigned BW    = 8,
  parameter int unsigned AW    = 2,
  parameter int unsigned DIV_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [RW-1:0]    wdata_i,
  output logic [RW-1:0]    rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [BW-1:0]    rx_i,
  output logic             start_o,
  output logic             sel_en_o,
  output logic [BW-1:0]    tx_o,
  output logic [DIV_W-1:0] div_o
);
  ctrl_t         ctrl_q;
  logic [BW-1:0] data_q;
  logic [RW-1:0] div_q;
  logic          wr_ok;
  reg_addr_e     ra;

  assign ra    = reg_addr_e'(addr_i);
  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ok && ra == RA_CTRL) begin
        ctrl_q.if_mode <= wdata_i[CTL_IFM];
        ctrl_q.big_end <= wdata_i[CTL_ORD];
        ctrl_q.sel_en  <= wdata_i[CTL_SEL];
        ctrl_q.cnt_m1  <= wdata_i[CTL_CNT_L +: 2];
        ctrl_q.op_code <= wdata_i[CTL_OP_L +: 3];
      end
      if (wr_ok && ra == RA_DIV) div_q <= wdata_i;
      if (done_i) begin
        data_q <= rx_i;
      end else if (wr_ok && ra == RA_DATA) begin
        data_q <= wdata_i[BW-1:0];
      end
    end
  end

  assign start_o  = wr_ok && (ra == RA_CTRL) && wdata_i[CTL_GO];
  assign sel_en_o = ctrl_q.sel_en;
  assign tx_o     = data_q;
  assign div_o    = div_q[DIV_MSB:DIV_LSB];

  always_comb begin
    rdata_o = '0;
    unique case (ra)
      RA_CTRL: begin
        rdata_o[CTL_GO]           = busy_i;
        rdata_o[CTL_IFM]          = ctrl_q.if_mode;
        rdata_o[CTL_ORD]          = ctrl_q.big_end;
        rdata_o[CTL_SEL]          = ctrl_q.sel_en;
        rdata_o[CTL_CNT_L +: 2]   = ctrl_q.cnt_m1;
        rdata_o[CTL_OP_L +: 3]    = ctrl_q.op_code;
      end
      RA_DATA: rdata_o = {{(RW-BW){1'b0}}, data_q};
      RA_DIV:  rdata_o = div_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master
  import byte_spi_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          cs_n_o
);
  localparam int unsigned DW = DIV_W;

  logic          busy;
  logic          done;
  logic          start_go;
  logic          sel_en;
  logic [BW-1:0] rx_byte;
  logic [BW-1:0] tx_byte;
  logic [DW-1:0] div_fld;
  logic [DW-1:0] lo_len;
  logic [DW-1:0] hi_len;

  spi_regs #(.RW(RW), .BW(BW), .AW(AW), .DIV_W(DW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy),
    .done_i   (done),
    .rx_i     (rx_byte),
    .start_o  (start_go),
    .sel_en_o (sel_en),
    .tx_o     (tx_byte),
    .div_o    (div_fld)
  );

  spi_phase_calc #(.DIV_W(DW)) i_phase (
    .div_i (div_fld),
    .lo_o  (lo_len),
    .hi_o  (hi_len)
  );

  spi_shift_engine #(.BW(BW), .DIV_W(DW)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_go),
    .tx_i    (tx_byte),
    .lo_i    (lo_len),
    .hi_i    (hi_len),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .done_o  (done),
    .rx_o    (rx_byte),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
  );

  assign cs_n_o = !sel_en;
endmodule

// File: rtl/byte_spi_master_chk.sv
module byte_spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic start_i,
  input logic sclk_i,
  input logic mosi_i,
  input logic cs_n_i
);
  // R4: accepted launch makes the engine busy on the next edge
  a_r4_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i);

  // R10: register block never issues a launch while the engine runs
  a_r10_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_i);

  // R3: select output held for the whole byte
  a_r3_cs_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cs_n_i));

  // R5: data out does not move while the serial clock is high
  a_r5_mosi_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> $stable(mosi_i));

  // R7: serial clock rests low outside a transfer
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);
endmodule

bind byte_spi_master byte_spi_master_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .start_i (start_go),
  .sclk_i  (sclk_o),
  .mosi_i  (mosi_o),
  .cs_n_i  (cs_n_o)
);

// File: tb/test_byte_spi_master.sv
module test_byte_spi_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [31:0] GO    = 32'h8000_0000;
  localparam logic [31:0] SEL   = 32'h0020_0000;
  localparam logic [31:0] OP4   = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int vecs = 0;
  int errs = 0;
  int hi_cnt = 0;
  int cs_cnt = 0;
  int rise_cnt = 0;
  logic [7:0] mosi_cap = '0;
  logic [7:0] slv_sh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_spi_master i_byte_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n)
  );

  // serial-side monitors and slave model
  always @(posedge sclk) begin
    mosi_cap = {mosi_cap[6:0], mosi};
    rise_cnt++;
  end
  always @(negedge sclk) begin
    slv_sh = {slv_sh[6:0], 1'b0};
    miso   = slv_sh[7];
  end
  always @(negedge clk) begin
    if (sclk) hi_cnt++;
    if (sclk && !cs_n) cs_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // called at the first falling edge after the accepting edge
  task automatic count_busy(output int n);
    n = 0;
    addr = A_CTRL;
    for (int g = 0; g < 5000; g++) begin
      #1;
      if (!rdata[31]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic xfer(input int d, input logic [7:0] tx, input logic [7:0] slv, input bit use_cs);
    int eff, hi, nb;
    logic [31:0] v;
    eff = (d < 2) ? 2 : d;
    hi  = eff - eff / 2;
    wr(A_DIV, 32'h8000_000F | (32'(d) << 4));
    wr(A_DATA, {24'h5A5A5A, tx});
    slv_sh = slv; miso = slv[7];
    hi_cnt = 0; cs_cnt = 0; rise_cnt = 0;
    wr(A_CTRL, GO | OP4 | (use_cs ? SEL : 32'h0));
    count_busy(nb);
    chk("R4/R8 busy cycles", 32'(nb), 32'(8 * eff));
    chk("R5 mosi byte", {24'h0, mosi_cap}, {24'h0, tx});
    chk("R7 high cycles", 32'(hi_cnt), 32'(8 * hi));
    chk("R7 sclk periods", 32'(rise_cnt), 32'd8);
    chk("R3 cs during byte", 32'(cs_cnt), use_cs ? 32'(8 * hi) : 32'd0);
    rd(A_DATA, v);
    chk("R6 rx byte", v, {24'h0, slv});
    rd(A_DIV, v);
    chk("R9 div readback", v, 32'h8000_000F | (32'(d) << 4));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nb;
    int dl [8] = '{0, 1, 2, 3, 4, 5, 6, 9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_DATA, v); chk("R1 data", v, 32'h0);
    rd(A_DIV, v);  chk("R1 div", v, 32'h0);
    chk("R1 pins", {29'h0, cs_n, sclk, mosi}, 32'h4);

    // R2 control fields, R3 select follows bit 21
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl fields", v, 32'h4063_0700);
    chk("R3 cs on", {31'h0, cs_n}, 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl cleared", v, 32'h0);
    chk("R3 cs off", {31'h0, cs_n}, 32'h1);

    // R11 data write readback
    wr(A_DATA, 32'hFFFF_FF96);
    rd(A_DATA, v); chk("R11 data wr", v, 32'h96);

    // near-exhaustive byte sweep, divider cycling incl. 0 and 1
    for (int i = 0; i < 256; i++) begin
      xfer(dl[i % 8], 8'(i), 8'(i) ^ 8'h5A ^ 8'(i >> 3), (i % 3) != 0);
    end

    // R10: writes during a running byte are ignored
    wr(A_DIV, 32'h0000_0090);
    wr(A_DATA, 32'h3C);
    slv_sh = 8'hC3; miso = 1'b1;
    wr(A_CTRL, GO | OP4 | SEL);
    wr(A_DATA, 32'hFF);
    wr(A_DIV, 32'h0000_0030);
    wr(A_CTRL, GO | 32'h4000_0000);
    count_busy(nb);
    rd(A_CTRL, v); chk("R10 ctrl unchanged", v, SEL | OP4);
    rd(A_DIV, v);  chk("R10 div unchanged", v, 32'h0000_0090);
    rd(A_DATA, v); chk("R10 data is rx", v, 32'hC3);
    chk("R10 mosi byte", {24'h0, mosi_cap}, 32'h3C);
    repeat (3) @(negedge clk);
    rd(A_CTRL, v); chk("R10 no relaunch", {31'h0, v[31]}, 32'h0);

    // R11: launch without new data write resends received byte
    slv_sh = 8'h00; miso = 1'b0;
    wr(A_CTRL, GO | OP4 | SEL);
    count_busy(nb);
    chk("R11 resend rx", {24'h0, mosi_cap}, 32'hC3);
    chk("R8 busy div9", 32'(nb), 32'd72);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule